// File: doc/BRIEF.md
# Selector-Addressed Shadow Register Bank

This block keeps a set of small 10-bit configuration registers that share one management register address. A host writes a 16-bit word to that address. Bits [14:10] name a slot. Bit 15 decides what else the write does. With bit 15 set, bits [9:0] are stored into the named slot. With bit 15 clear, the slot's contents are left alone and the selector is only recorded, so the next read returns that slot.

A read strobe captures a 16-bit response word. Bit 15 is zero, bits [14:10] echo the current selector, and bits [9:0] hold the selected slot. The response is held until the next read strobe.

Slot 5'b00100 is a spare-control slot, and most of its bits are fixed. Its bit 1 picks the source of the interrupt output pin: the ordinary interrupt request or an energy-detect indication. Which slots exist is set by a parameter mask. Slots left out of the mask ignore writes and read as zero.

Top module: `shadow_bank`

## Requirements
- R1: A write with bit 15 = 1 to an implemented slot other than 5'b00100 stores wdata[9:0] into the slot named by wdata[14:10].
- R2: A write with bit 15 = 0 changes no slot contents. It only records wdata[14:10] as the selector.
- R3: Every write, whatever its bit 15, sets the selector to wdata[14:10]. A read strobe loads rdata with {1'b0, selector, slot[9:0]}, visible after that clock edge. rdata keeps its value in every cycle without a read strobe.
- R4: Slot 5'b00100 always reads bits [9:5] as 0, bits [4:2] as 3'b011 and bit 0 as 0, whatever is written.
- R5: Bit 1 of slot 5'b00100 is writable and resets to 0.
- R6: irq_out equals energy_det while bit 1 of slot 5'b00100 is 1, and irq_req while it is 0. A write that changes that bit takes effect at the clock edge that accepts the write.
- R7: During and after reset, every implemented slot holds its initial value (all zero except the fixed bits of R4), the selector is 5'b00000, and rdata is 16'h0000.
- R8: A write with bit 15 = 1 to a slot outside IMPL_MASK has no effect on any slot. A read of such a slot returns 0 in bits [9:0], and the selector is still echoed in bits [14:10].
- R9: When the read strobe and the write strobe are high in the same cycle, the read returns the selector and slot contents as they were before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the shared address |
| rd_en | input | 1 | Read strobe for the shared address |
| wdata | input | 16 | Write word: [15] store enable, [14:10] selector, [9:0] value |
| rdata | output | 16 | Captured read word: [15] zero, [14:10] selector, [9:0] slot |
| irq_req | input | 1 | Ordinary interrupt request |
| energy_det | input | 1 | Energy-detect indication |
| irq_out | output | 1 | Interrupt pin, selected by slot 5'b00100 bit 1 |

## Verification
A read strobe and a write strobe can land in the same cycle. In that cycle the read capture must see the old selector and the old slot value, while the write updates both. The bench provokes this in two ways. It issues a write that stores a new value into the slot being read while a read is pending, and it issues a write that moves the selector to another slot. Its cycle model applies the read before the write and checks rdata and irq_out against that model on every clock.

// File: rtl/shadow_bank.sv
module shadow_bank #(
  parameter int SEL_W  = 5,
  parameter int SLOT_W = 10,
  parameter logic [(1<<SEL_W)-1:0] IMPL_MASK = 'hFF,
  parameter int SPARE_SEL  = 4,
  parameter int IRQSRC_BIT = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [SEL_W+SLOT_W:0]     wdata,
  output logic [SEL_W+SLOT_W:0]     rdata,
  input  logic                      irq_req,
  input  logic                      energy_det,
  output logic                      irq_out
);
  localparam int NSLOT  = 1 << SEL_W;
  localparam int WORD_W = SEL_W + SLOT_W + 1;
  localparam int WE_BIT = WORD_W - 1;
  localparam logic [SLOT_W-1:0] SPARE_FIX = SLOT_W'(12);

  logic              wr_we;
  logic [SEL_W-1:0]  wr_sel;
  logic [SLOT_W-1:0] wr_val;
  logic [SEL_W-1:0]  sel_q;
  logic [WORD_W-1:0] rdata_q;
  logic [SLOT_W-1:0] slot_rd [NSLOT];
  logic [NSLOT*SLOT_W-1:0] bank_flat;

  assign wr_we  = wdata[WE_BIT];
  assign wr_sel = wdata[WE_BIT-1 -: SEL_W];
  assign wr_val = wdata[SLOT_W-1:0];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (!IMPL_MASK[i]) begin : g_absent
      assign slot_rd[i] = '0;
    end else if (i == SPARE_SEL) begin : g_spare
      logic src_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) src_q <= 1'b0;
        else if (wr_en && wr_we && wr_sel == SEL_W'(i)) src_q <= wr_val[IRQSRC_BIT];
      assign slot_rd[i] = SPARE_FIX | (SLOT_W'(src_q) << IRQSRC_BIT);
    end else begin : g_plain
      logic [SLOT_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else if (wr_en && wr_we && wr_sel == SEL_W'(i)) q <= wr_val;
      assign slot_rd[i] = q;
    end
    assign bank_flat[i*SLOT_W +: SLOT_W] = slot_rd[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sel_q <= '0;
    else if (wr_en) sel_q <= wr_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdata_q <= '0;
    else if (rd_en) rdata_q <= {1'b0, sel_q, slot_rd[sel_q]};

  assign rdata   = rdata_q;
  assign irq_out = slot_rd[SPARE_SEL][IRQSRC_BIT] ? energy_det : irq_req;
endmodule

// File: rtl/shadow_bank_chk.sv
module shadow_bank_chk #(
  parameter int SEL_W  = 5,
  parameter int SLOT_W = 10,
  parameter logic [(1<<SEL_W)-1:0] IMPL_MASK = 'hFF,
  parameter int SPARE_SEL  = 4,
  parameter int IRQSRC_BIT = 1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wr_en,
  input logic                          rd_en,
  input logic [SEL_W+SLOT_W:0]         wdata,
  input logic [SEL_W+SLOT_W:0]         rdata,
  input logic                          irq_req,
  input logic                          energy_det,
  input logic                          irq_out,
  input logic [SEL_W-1:0]              sel,
  input logic [(1<<SEL_W)*SLOT_W-1:0]  bank
);
  localparam int WE_BIT = SEL_W + SLOT_W;

  // R2
  keep_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[WE_BIT]) |=> $stable(bank));

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R3
  sel_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rdata[WE_BIT:SLOT_W] == {1'b0, $past(sel)}));

  // R4
  spare_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_W'(SPARE_SEL)) |=> (rdata[SLOT_W-1:2] == (SLOT_W-2)'(3) && !rdata[0]));

  // R6
  irq_ed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[WE_BIT] && wdata[WE_BIT-1 -: SEL_W] == SEL_W'(SPARE_SEL) && wdata[IRQSRC_BIT])
      |=> (irq_out == energy_det));

  // R6
  irq_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[WE_BIT] && wdata[WE_BIT-1 -: SEL_W] == SEL_W'(SPARE_SEL) && !wdata[IRQSRC_BIT])
      |=> (irq_out == irq_req));

  // R8
  absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !IMPL_MASK[sel]) |=> (rdata[SLOT_W-1:0] == '0));

  // R8
  absent_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !IMPL_MASK[wdata[WE_BIT-1 -: SEL_W]]) |=> $stable(bank));
endmodule

bind shadow_bank shadow_bank_chk #(
  .SEL_W(SEL_W), .SLOT_W(SLOT_W), .IMPL_MASK(IMPL_MASK),
  .SPARE_SEL(SPARE_SEL), .IRQSRC_BIT(IRQSRC_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
  .rdata(rdata), .irq_req(irq_req), .energy_det(energy_det), .irq_out(irq_out),
  .sel(sel_q), .bank(bank_flat)
);

// File: tb/shadow_bank_tb.sv
module shadow_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq_req = 1'b0;
  logic        energy_det = 1'b0;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  int slot_m [32];
  int sel_m = 0;
  logic [15:0] exp_rd = '0;

  always #10 clk = ~clk;

  shadow_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .irq_req(irq_req), .energy_det(energy_det), .irq_out(irq_out)
  );

  function automatic int m_read(int s);
    if (s > 7) return 0;
    if (s == 4) return 12 | (slot_m[4] & 2);
    return slot_m[s];
  endfunction

  task automatic check(string tag);
    logic exp_irq;
    exp_irq = (slot_m[4] & 2) != 0 ? energy_det : irq_req;
    total++;
    if (rdata !== exp_rd) begin
      bad++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, rdata, exp_rd);
    end
    total++;
    if (irq_out !== exp_irq) begin
      bad++;
      $display("FAIL %s irq_out actual=%b expected=%b", tag, irq_out, exp_irq);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic [15:0] d,
                      input logic iq, input logic ed, input string tag);
    int s;
    wr_en = w; rd_en = r; wdata = d; irq_req = iq; energy_det = ed;
    @(posedge clk);
    if (r) exp_rd = {1'b0, sel_m[4:0], m_read(sel_m)[9:0]};
    if (w) begin
      s = int'(d[14:10]);
      sel_m = s;
      if (d[15] && s <= 7) slot_m[s] = (s == 4) ? (int'(d) & 2) : (int'(d) & 'h3FF);
    end
    @(negedge clk);
    check(tag);
  endtask

  function automatic logic [15:0] wr_word(logic we, int s, int v);
    return {we, s[4:0], v[9:0]};
  endfunction

  task automatic arm_read(int s, string tag);
    step(1'b1, 1'b0, wr_word(1'b0, s, 0), irq_req, energy_det, tag);
    step(1'b0, 1'b1, '0, irq_req, energy_det, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) slot_m[i] = 0;
    repeat (2) @(negedge clk);
    check("R7 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 after reset");
    step(1'b0, 1'b1, '0, 1'b1, 1'b0, "R7 read slot0 after reset");
    arm_read(4, "R5 spare reset value");

    step(1'b1, 1'b0, wr_word(1'b1, 2, 'h2A5), 1'b0, 1'b0, "R1 write slot2");
    arm_read(2, "R1 readback slot2");
    step(1'b1, 1'b0, wr_word(1'b0, 2, 'h155), 1'b0, 1'b0, "R2 arm no store");
    step(1'b0, 1'b1, '0, 1'b0, 1'b0, "R2 slot2 unchanged");
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 16'hFFFF, 1'b1, 1'b1, "R3 hold");

    for (int s = 0; s < 8; s++)
      step(1'b1, 1'b0, wr_word(1'b1, s, (s * 'h71 + 'h0F) & 'h3FD), 1'b0, 1'b1, "R1 fill");
    for (int s = 0; s < 8; s++) arm_read(s, "R1 R4 sweep");

    step(1'b1, 1'b0, wr_word(1'b1, 4, 'h3FF), 1'b0, 1'b1, "R6 select energy");
    arm_read(4, "R4 fixed bits");
    step(1'b0, 1'b0, '0, 1'b1, 1'b0, "R6 ed low");
    step(1'b0, 1'b0, '0, 1'b0, 1'b1, "R6 ed high");
    step(1'b1, 1'b0, wr_word(1'b1, 4, 'h3FD), 1'b1, 1'b1, "R5 clear src");
    step(1'b0, 1'b0, '0, 1'b0, 1'b1, "R6 irq path");
    step(1'b0, 1'b0, '0, 1'b1, 1'b0, "R6 irq path");
    arm_read(4, "R4 R5 cleared");

    step(1'b1, 1'b0, wr_word(1'b1, 9, 'h3FF), 1'b0, 1'b0, "R8 write absent");
    step(1'b0, 1'b1, '0, 1'b0, 1'b0, "R8 read absent");
    step(1'b1, 1'b0, wr_word(1'b1, 31, 'h2AA), 1'b0, 1'b0, "R8 write top");
    step(1'b0, 1'b1, '0, 1'b0, 1'b0, "R8 read top");
    for (int s = 0; s < 8; s++) arm_read(s, "R8 bank intact");

    arm_read(3, "R9 setup");
    step(1'b1, 1'b1, wr_word(1'b1, 3, 'h0F0), 1'b0, 1'b0, "R9 same slot old value");
    step(1'b0, 1'b1, '0, 1'b0, 1'b0, "R9 new value after");
    step(1'b1, 1'b1, wr_word(1'b0, 6, 0), 1'b0, 1'b0, "R9 old selector");
    step(1'b0, 1'b1, '0, 1'b0, 1'b0, "R9 new selector after");
    step(1'b1, 1'b1, wr_word(1'b1, 4, 'h002), 1'b1, 1'b0, "R9 R6 spare same cycle");
    step(1'b0, 1'b1, '0, 1'b0, 1'b1, "R6 energy after");

    rst_n = 1'b0;
    for (int i = 0; i < 32; i++) slot_m[i] = 0;
    sel_m = 0;
    exp_rd = '0;
    #1;
    check("R7 reset again");
    @(negedge clk);
    rst_n = 1'b1;
    arm_read(2, "R7 slot2 cleared");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule